// File: doc/BRIEF.md
# Pixel Port Luma/Chroma Demultiplexer

This block sits behind a digital video pixel port and splits 4:2:2 YCbCr samples into a luma byte and its co-sited chroma byte. One datapath serves two port arrangements chosen by a static mode pin. The first is a single byte lane carrying interleaved chroma and luma at the full clock rate. The second is a pair of byte lanes, luma on the low lane and interleaved chroma on the high lane, taken at half the clock rate. In both modes the chroma components alternate with Cb first.

Each completed luma sample leaves the block as a one-cycle strobe. The strobe carries the luma byte, the chroma byte that belongs to it and a flag telling whether that chroma byte is Cb or Cr. The reserved codes all-zeros and all-ones mark embedded timing references. A complete reference re-aligns the chroma phase, and the reference bytes never reach the output. The output has no back-pressure: there is no ready input. The consumer must take every strobe in the cycle it appears. Between strobes the data outputs hold their last values.

Top module: `pxd_demux_top`

## Requirements
- R1: With `wide_mode`=0, the bytes on `pix_lo` are taken in a repeating Cb, Y, Cr, Y order. Each Y byte produces one strobe carrying that Y byte and the chroma byte just before it, with `c_is_cr`=0 after a Cb byte and `c_is_cr`=1 after a Cr byte.
- R2: A byte sampled at clock edge k appears on the outputs after edge k+1. `out_valid` is never high in two consecutive cycles.
- R3: With `wide_mode`=1, the port is sampled at the first rising edge after reset is released and then on every second edge only. Each sampled word produces one strobe with `y_out`=`pix_lo` and `c_out`=`pix_hi`.
- R4: With `wide_mode`=1, `c_is_cr` alternates on successive strobes, and the first strobe after reset or after a timing reference has `c_is_cr`=0.
- R5: Every byte value that is not part of a timing reference passes through unchanged, including 1, 254 and an all-zeros byte that does not follow an all-ones byte.
- R6: The byte sequence all-ones, zero, zero, any (on `pix_lo` in the narrow mode, on `pix_hi` in the wide mode) is a timing reference. None of its four bytes or words produces a strobe, and the next byte or word is taken as Cb.
- R7: An all-ones byte followed by a byte that is neither zero nor the completing byte breaks the reference. The bytes consumed so far produce no strobe and the chroma phase is left as it was. A breaking all-ones byte starts a new reference.
- R8: While `rst` is high at a rising edge, the block clears `out_valid`, `y_out`, `c_out` and `c_is_cr` and resets the chroma phase to Cb.
- R9: While `out_valid` is low, `y_out`, `c_out` and `c_is_cr` keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock; every register uses its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wide_mode | input | 1 | 0: one interleaved byte lane; 1: split luma/chroma lanes at half rate; change only while in reset |
| pix_lo | input | BYTE_W | Interleaved stream (narrow mode) or luma (wide mode) |
| pix_hi | input | BYTE_W | Interleaved chroma (wide mode); ignored in narrow mode |
| y_out | output | BYTE_W | Luma of the current sample |
| c_out | output | BYTE_W | Chroma byte paired with `y_out` |
| c_is_cr | output | 1 | 1 when `c_out` is Cr, 0 when Cb |
| out_valid | output | 1 | One-cycle strobe per luma sample, no back-pressure |

## Verification
The narrow mode is first driven with a stream that starts cleanly on Cb straight out of reset. This shows the basic phase order and the pairing of each luma byte with the chroma byte before it. Stray bytes followed by a timing reference then separate a design that re-aligns from one that keeps counting. An interrupted reference, and one restarted by a second all-ones byte, show whether dropped bytes disturb the phase. In the wide mode, words held for two cycles and a reference carried on the chroma lane show the half-rate sampling, the lane assignment and the Cb-first restart. Boundary values 1, 254 and a lone zero confirm that data is passed through unchanged.

// File: rtl/pxd_pkg.sv
package pxd_pkg;

  // progress through an embedded timing reference
  typedef enum logic [1:0] {
    TRS_IDLE   = 2'd0,
    TRS_ONES   = 2'd1,
    TRS_ZERO1  = 2'd2,
    TRS_ZERO2  = 2'd3
  } trs_state_e;

  // position inside the four-byte chroma/luma cycle
  typedef enum logic [1:0] {
    PH_CB  = 2'd0,
    PH_YB  = 2'd1,
    PH_CR  = 2'd2,
    PH_YR  = 2'd3
  } phase_e;

endpackage

// File: rtl/pxd_capture.sv
module pxd_capture #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wide_mode,
  input  logic [BYTE_W-1:0] lo_i,
  input  logic [BYTE_W-1:0] hi_i,
  output logic              stb_o,
  output logic [BYTE_W-1:0] lo_o,
  output logic [BYTE_W-1:0] hi_o
);

  // in wide mode every second edge is skipped
  logic skip_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      skip_q <= 1'b0;
      stb_o  <= 1'b0;
      lo_o   <= '0;
      hi_o   <= '0;
    end else begin
      stb_o  <= !wide_mode || !skip_q;
      skip_q <= wide_mode && !skip_q;
      lo_o   <= lo_i;
      hi_o   <= hi_i;
    end
  end

endmodule

// File: rtl/pxd_trs_detect.sv
module pxd_trs_detect
  import pxd_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stb_i,
  input  logic [BYTE_W-1:0] code_i,
  output logic              drop_o,
  output logic              realign_o
);

  localparam logic [BYTE_W-1:0] CODE_ONES = {BYTE_W{1'b1}};
  localparam logic [BYTE_W-1:0] CODE_ZERO = {BYTE_W{1'b0}};

  trs_state_e st_q, st_d;
  logic is_ones, is_zero;

  assign is_ones = (code_i == CODE_ONES);
  assign is_zero = (code_i == CODE_ZERO);

  assign drop_o    = stb_i && ((st_q != TRS_IDLE) || is_ones);
  assign realign_o = stb_i && (st_q == TRS_ZERO2);

  always_comb begin
    st_d = st_q;
    if (stb_i) begin
      unique case (st_q)
        TRS_IDLE:  st_d = is_ones ? TRS_ONES : TRS_IDLE;
        TRS_ONES:  st_d = is_zero ? TRS_ZERO1 : (is_ones ? TRS_ONES : TRS_IDLE);
        TRS_ZERO1: st_d = is_zero ? TRS_ZERO2 : (is_ones ? TRS_ONES : TRS_IDLE);
        TRS_ZERO2: st_d = TRS_IDLE;
        default:   st_d = TRS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= TRS_IDLE;
    else     st_q <= st_d;
  end

endmodule

// File: rtl/pxd_phase.sv
module pxd_phase
  import pxd_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wide_mode,
  input  logic              stb_i,
  input  logic              drop_i,
  input  logic              realign_i,
  input  logic [BYTE_W-1:0] lo_i,
  input  logic [BYTE_W-1:0] hi_i,
  output logic [BYTE_W-1:0] y_o,
  output logic [BYTE_W-1:0] c_o,
  output logic              cr_o,
  output logic              vld_o
);

  phase_e            ph_q;
  logic [BYTE_W-1:0] c_hold_q;
  logic              take;

  assign take = stb_i && !drop_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q     <= PH_CB;
      c_hold_q <= '0;
      y_o      <= '0;
      c_o      <= '0;
      cr_o     <= 1'b0;
      vld_o    <= 1'b0;
    end else begin
      vld_o <= 1'b0;
      if (realign_i) begin
        ph_q <= PH_CB;
      end else if (take) begin
        if (wide_mode) begin
          // one complete sample per word; phase stays on chroma slots
          y_o   <= lo_i;
          c_o   <= hi_i;
          cr_o  <= (ph_q == PH_CR);
          vld_o <= 1'b1;
          ph_q  <= (ph_q == PH_CR) ? PH_CB : PH_CR;
        end else begin
          unique case (ph_q)
            PH_CB, PH_CR: c_hold_q <= lo_i;
            PH_YB, PH_YR: begin
              y_o   <= lo_i;
              c_o   <= c_hold_q;
              cr_o  <= (ph_q == PH_YR);
              vld_o <= 1'b1;
            end
            default: ;
          endcase
          ph_q <= phase_e'(ph_q + 2'd1);
        end
      end
    end
  end

endmodule

// File: rtl/pxd_demux_top.sv
module pxd_demux_top #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wide_mode,
  input  logic [BYTE_W-1:0] pix_lo,
  input  logic [BYTE_W-1:0] pix_hi,
  output logic [BYTE_W-1:0] y_out,
  output logic [BYTE_W-1:0] c_out,
  output logic              c_is_cr,
  output logic              out_valid
);

  logic              stb_w;
  logic [BYTE_W-1:0] lo_w, hi_w, code_w;
  logic              drop_w, realign_w;

  pxd_capture #(.BYTE_W(BYTE_W)) u_cap (
    .clk       (clk),
    .rst       (rst),
    .wide_mode (wide_mode),
    .lo_i      (pix_lo),
    .hi_i      (pix_hi),
    .stb_o     (stb_w),
    .lo_o      (lo_w),
    .hi_o      (hi_w)
  );

  // timing codes ride the interleaved lane of whichever mode is active
  assign code_w = wide_mode ? hi_w : lo_w;

  pxd_trs_detect #(.BYTE_W(BYTE_W)) u_trs (
    .clk       (clk),
    .rst       (rst),
    .stb_i     (stb_w),
    .code_i    (code_w),
    .drop_o    (drop_w),
    .realign_o (realign_w)
  );

  pxd_phase #(.BYTE_W(BYTE_W)) u_ph (
    .clk       (clk),
    .rst       (rst),
    .wide_mode (wide_mode),
    .stb_i     (stb_w),
    .drop_i    (drop_w),
    .realign_i (realign_w),
    .lo_i      (lo_w),
    .hi_i      (hi_w),
    .y_o       (y_out),
    .c_o       (c_out),
    .cr_o      (c_is_cr),
    .vld_o     (out_valid)
  );

endmodule

// File: rtl/pxd_demux_checks.sv
module pxd_demux_checks #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wide_mode,
  input logic [BYTE_W-1:0] pix_lo,
  input logic [BYTE_W-1:0] pix_hi,
  input logic [BYTE_W-1:0] y_out,
  input logic [BYTE_W-1:0] c_out,
  input logic              c_is_cr,
  input logic              out_valid,
  input logic              realign
);

  logic rst_q     = 1'b0;
  logic restart_q = 1'b0;
  logic have_q    = 1'b0;
  logic last_q    = 1'b0;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) begin
      restart_q <= 1'b1;
      have_q    <= 1'b0;
      last_q    <= 1'b0;
    end else begin
      if (realign)        restart_q <= 1'b1;
      else if (out_valid) restart_q <= 1'b0;
      if (out_valid) begin
        have_q <= 1'b1;
        last_q <= c_is_cr;
      end
    end
  end

  // R8: outputs cleared one cycle after a reset edge
  a_r8_reset_clear: assert property (@(posedge clk)
    rst_q |-> (!out_valid && y_out == '0 && c_out == '0 && !c_is_cr));

  // R2: strobes never back to back
  a_r2_spacing: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R9: outputs hold between strobes
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> ($stable(y_out) && $stable(c_out) && $stable(c_is_cr)));

  // R3: wide mode lanes map straight through two edges later
  a_r3_wide_lanes: assert property (@(posedge clk) disable iff (rst)
    (wide_mode && out_valid) |-> (y_out == $past(pix_lo, 2) && c_out == $past(pix_hi, 2)));

  // R4: chroma flag alternates while no re-alignment intervenes
  a_r4_alternate: assert property (@(posedge clk) disable iff (rst)
    (out_valid && have_q && !restart_q) |-> (c_is_cr != last_q));

  // R6: first sample after reset or reference carries Cb
  a_r6_cb_first: assert property (@(posedge clk) disable iff (rst)
    (out_valid && restart_q) |-> !c_is_cr);

endmodule

bind pxd_demux_top pxd_demux_checks #(.BYTE_W(BYTE_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wide_mode (wide_mode),
  .pix_lo    (pix_lo),
  .pix_hi    (pix_hi),
  .y_out     (y_out),
  .c_out     (c_out),
  .c_is_cr   (c_is_cr),
  .out_valid (out_valid),
  .realign   (realign_w)
);

// File: tb/pxd_demux_top_tb.sv
module pxd_demux_top_tb;

  localparam int BW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wide_mode = 1'b0;
  logic [BW-1:0] pix_lo = '0;
  logic [BW-1:0] pix_hi = '0;
  logic [BW-1:0] y_out, c_out;
  logic          c_is_cr, out_valid;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  string cur_req = "R8";

  always #5 clk = ~clk;

  pxd_demux_top #(.BYTE_W(BW)) u_dut (
    .clk       (clk),
    .rst       (rst),
    .wide_mode (wide_mode),
    .pix_lo    (pix_lo),
    .pix_hi    (pix_hi),
    .y_out     (y_out),
    .c_out     (c_out),
    .c_is_cr   (c_is_cr),
    .out_valid (out_valid)
  );

  // ---------------- behavioural reference ----------------
  int  edge_n, trs_seen, slot;
  bit  pend_v;
  int  pend_lo, pend_hi;
  int  chroma_q[$];
  bit  exp_v, exp_f;
  int  exp_y, exp_c;

  task automatic model_consume(input int lo, input int hi);
    int b;
    b = wide_mode ? hi : lo;
    if (trs_seen == 3) begin
      trs_seen = 0;
      slot = 0;
      chroma_q.delete();
      return;
    end
    if (trs_seen > 0) begin
      if (b == 0) trs_seen++;
      else if (b == 255) trs_seen = 1;
      else trs_seen = 0;
      return;
    end
    if (b == 255) begin
      trs_seen = 1;
      return;
    end
    if (wide_mode) begin
      exp_v = 1; exp_y = lo; exp_c = hi; exp_f = (slot != 0);
      slot = (slot == 0) ? 1 : 0;
    end else begin
      if (slot % 2 == 0) begin
        chroma_q.push_back(lo);
      end else begin
        exp_v = 1; exp_y = lo;
        exp_c = (chroma_q.size() > 0) ? chroma_q.pop_front() : 0;
        exp_f = (slot == 3);
      end
      slot = (slot + 1) % 4;
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      edge_n = 0; trs_seen = 0; slot = 0; pend_v = 0;
      chroma_q.delete();
      exp_v = 0; exp_y = 0; exp_c = 0; exp_f = 0;
    end else begin
      exp_v = 0;
      if (pend_v) model_consume(pend_lo, pend_hi);
      pend_v  = !wide_mode || (edge_n % 2 == 0);
      pend_lo = pix_lo;
      pend_hi = pix_hi;
      edge_n++;
    end
  end

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
    end
  endtask

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    cycles++;
    check(out_valid == exp_v, "valid", out_valid, exp_v);
    check(y_out == exp_y[BW-1:0], "y", y_out, exp_y);
    check(c_out == exp_c[BW-1:0], "c", c_out, exp_c);
    check(c_is_cr == exp_f, "cr_flag", c_is_cr, exp_f);
  end

  // ---------------- stimulus ----------------
  task automatic put8(input int b);
    @(negedge clk);
    pix_lo = b[BW-1:0];
  endtask

  task automatic put16(input int y, input int c);
    @(negedge clk);
    pix_lo = y[BW-1:0];
    pix_hi = c[BW-1:0];
    @(negedge clk);
  endtask

  task automatic do_reset(input bit wide);
    @(negedge clk);
    rst = 1'b1;
    wide_mode = wide;
    repeat (3) @(negedge clk);
    cur_req = "R8";
    check(!out_valid && y_out == 0 && c_out == 0, "reset state", out_valid, 0);
    rst = 1'b0;
  endtask

  initial begin : stim
    do_reset(1'b0);

    // narrow mode aligned from reset; includes boundary values
    cur_req = "R1 R2 R5 R9";
    put8(8'h80); put8(8'h10); put8(8'h90); put8(8'hEB);
    put8(8'h01); put8(8'hFE); put8(8'hFE); put8(8'h01);
    put8(8'h40); put8(8'h00); put8(8'hC0); put8(8'h7F);
    put8(8'h11); put8(8'h22); put8(8'h33); put8(8'h44);

    // stray bytes then a timing reference re-aligns to Cb
    cur_req = "R6";
    put8(8'h55); put8(8'h66); put8(8'h77);
    put8(8'hFF); put8(8'h00); put8(8'h00); put8(8'h9D);
    put8(8'hA0); put8(8'h20); put8(8'hB0); put8(8'h30);
    put8(8'hA1); put8(8'h21); put8(8'hB1); put8(8'h31);

    // broken and restarted references
    cur_req = "R7";
    put8(8'hA2); put8(8'hFF); put8(8'h12);
    put8(8'h22); put8(8'hB2); put8(8'h32);
    put8(8'hFF); put8(8'h00); put8(8'hFF); put8(8'h00); put8(8'h00); put8(8'hF1);
    put8(8'hC3); put8(8'h43); put8(8'hD3); put8(8'h53);
    put8(8'hC4); put8(8'h44);
    repeat (4) put8(8'h10);

    // wide mode from reset
    do_reset(1'b1);
    cur_req = "R3 R4 R5 R9";
    put16(8'h10, 8'h80); put16(8'hEB, 8'h90);
    put16(8'h01, 8'hFE); put16(8'hFE, 8'h01);
    put16(8'h00, 8'h40); put16(8'h7E, 8'hC0);
    put16(8'h35, 8'h60);

    // reference on the chroma lane restarts at Cb
    cur_req = "R6";
    put16(8'h10, 8'hFF); put16(8'h10, 8'h00); put16(8'h10, 8'h00); put16(8'h10, 8'hB6);
    put16(8'h21, 8'h71); put16(8'h22, 8'h72); put16(8'h23, 8'h73);
    cur_req = "R7";
    put16(8'h10, 8'hFF); put16(8'h10, 8'h05);
    put16(8'h24, 8'h74); put16(8'h25, 8'h75);
    repeat (4) put16(8'h10, 8'h80);

    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule